// File: doc/BRIEF.md
# Stop-Clock Power State Controller

This block sequences a processor core through five clocking states: run, halted (auto power down), stop granted, snoop while stopped, and clock off. It watches a stop-clock request, a halt-instruction strobe, six interrupt lines, an inquire-cycle strobe with its completion flag, a flag that says the external clock is present, and a bus hold request. From the current state it derives enables for the PLL, the main clocks and instruction execution. It also issues a one-cycle stop-grant bus-cycle strobe and drives the hold acknowledge.

Snoop, stop-grant and clock-off are temporary states. On entry to one of them the state being left is pushed onto a two-entry return stack. On leaving, the entry is popped. A chain such as halted, then stop granted, then snoop therefore unwinds to halted. The stop-clock request ranks below every interrupt line. Leaving the clock-off state requires a counted restart window once the external clock comes back.

All transitions are registered: an input seen at one clock edge changes the state at that edge, and the new state is visible in the following cycle.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n` is low, the controller resets on the clock edge. After reset, `cur_state` is 0, `sg_cycle` is 0, `hlda` is 0 and all three enables are 1. The state codes are 0 run, 1 halted, 2 stop granted, 3 snoop, 4 clock off.
- R2: In run with no stop-grant sequence pending, `halt_stb` moves the state to halted.
- R3: Halted returns to run only when `irq_intr`, `irq_nmi`, `irq_smi`, `irq_reset` or `irq_init` is high. `irq_flush` alone leaves the state halted.
- R4: The stop-grant sequence starts when `stop_req` is high and no interrupt line is high, and either the state is halted or the state is run with `insn_done` high. `sg_cycle` is then high for exactly one cycle, and the state becomes stop granted in the cycle after that.
- R5: While any of the six interrupt lines is high, no stop-grant sequence starts.
- R6: Once the sequence has started, negating `stop_req` before the strobe has gone out has no effect. Stop granted is still entered.
- R7: Stop granted returns to the state it was entered from when `stop_req` is low. Interrupt lines do not cause an exit.
- R8: `inq_stb` in halted or stop granted moves to snoop. Snoop holds until `coh_done` is high, then returns to the interrupted state. Nested entries unwind in reverse order.
- R9: Stop granted with `ext_clk_ok` low moves to clock off. Clock off returns to stop granted after `RESTART_CYCLES` consecutive cycles with `ext_clk_ok` high. A clock loss during the window restarts the count.
- R10: `pll_en` is 1 in every state except clock off. `mclk_en` is 1 in run, halted and snoop. `exec_en` is 1 only in run.
- R11: `hlda` follows `hold_req` one cycle later outside clock off. In clock off it is set only if `hold_req` is high while `ext_clk_ok` is high. It is always cleared one cycle after `hold_req` goes low.
- R12: `inq_stb` in run has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | Stop-clock request |
| insn_done | input | 1 | Current instruction has finished |
| halt_stb | input | 1 | Halt instruction executed |
| irq_intr | input | 1 | Maskable interrupt |
| irq_nmi | input | 1 | Non-maskable interrupt |
| irq_smi | input | 1 | System management interrupt |
| irq_reset | input | 1 | Power-on reset request |
| irq_init | input | 1 | Soft reset request |
| irq_flush | input | 1 | Cache flush request |
| inq_stb | input | 1 | Inquire cycle detected |
| coh_done | input | 1 | Coherency operation complete |
| ext_clk_ok | input | 1 | External clock present |
| hold_req | input | 1 | Bus hold request |
| cur_state | output | 3 | Current clocking state code |
| pll_en | output | 1 | PLL enable |
| mclk_en | output | 1 | Main clock enable |
| exec_en | output | 1 | Instruction execution enable |
| sg_cycle | output | 1 | Stop-grant bus-cycle strobe |
| hlda | output | 1 | Hold acknowledge |

## Verification
The assertions check the following on every cycle:
- The strobe lasts a single cycle and is always followed by stop granted.
- Stop granted is never entered from run or halted without the strobe.
- Halted leaves for run only on a wake interrupt.
- Snoop and stop granted hold while their exit conditions are absent.
- Clock off exits only to stop granted.
- Hold acknowledge drops whenever hold is low in clock off.

Some behaviour only the directed scenarios can show. This covers the return-stack unwinding through nested temporary states and the exact length of the restart window. It also covers the interrupt hold-off of a stop request and the ignored early negation of the request.

// File: rtl/clkstop_pkg.sv
// Shared types for the stop-clock controller.
// Assumes: state codes are visible at the top-level port and must not move.
package clkstop_pkg;
    typedef enum logic [2:0] {
        CS_RUN   = 3'd0,
        CS_HALT  = 3'd1,
        CS_GRANT = 3'd2,
        CS_SNOOP = 3'd3,
        CS_OFF   = 3'd4
    } cs_state_e;
endpackage

// File: rtl/clkstop_retstack.sv
// Return stack for temporary clocking states.
// Pushes the state being left and pops the state to resume.
// Assumes: push and pop are never high together. Popping an empty stack yields run.
module clkstop_retstack
    import clkstop_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  logic      pop,
    input  cs_state_e push_st,
    output cs_state_e top_st
);
    cs_state_e ent_q [DEPTH];

    // Shift entries down on push and up on pop. Reset clears every entry to run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= CS_RUN;
        end else if (push) begin
            ent_q[0] <= push_st;
            for (int i = 1; i < DEPTH; i++) ent_q[i] <= ent_q[i-1];
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) ent_q[i] <= ent_q[i+1];
            ent_q[DEPTH-1] <= CS_RUN;
        end
    end

    assign top_st = ent_q[0];
endmodule

// File: rtl/clkstop_restart.sv
// Restart window timer for the clock-off state.
// Counts consecutive cycles of 'run' and flags the last one.
// Assumes: CYCLES >= 2. 'run' dropping clears the count.
module clkstop_restart #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Advance while run is high, otherwise hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/clkstop_enables.sv
// Per-state clock and execution enable decode.
// Assumes: state is the registered controller state, so the outputs are glitch-free per cycle.
module clkstop_enables
    import clkstop_pkg::*;
(
    input  cs_state_e st,
    output logic      pll_en,
    output logic      mclk_en,
    output logic      exec_en
);
    // Decode the enables from the state code.
    always_comb begin
        pll_en  = (st != CS_OFF);
        mclk_en = (st == CS_RUN) || (st == CS_HALT) || (st == CS_SNOOP);
        exec_en = (st == CS_RUN);
    end
endmodule

// File: rtl/clkstop_ctrl.sv
// Stop-clock power state controller (top).
// Sequences run, halted, stop granted, snoop and clock off.
// Temporary states resume through a return stack.
// Assumes: inputs are synchronous to clk. The external clock loss is given as ext_clk_ok.
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int RESTART_CYCLES = 1000,
    parameter int STACK_DEPTH    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       insn_done,
    input  logic       halt_stb,
    input  logic       irq_intr,
    input  logic       irq_nmi,
    input  logic       irq_smi,
    input  logic       irq_reset,
    input  logic       irq_init,
    input  logic       irq_flush,
    input  logic       inq_stb,
    input  logic       coh_done,
    input  logic       ext_clk_ok,
    input  logic       hold_req,
    output logic [2:0] cur_state,
    output logic       pll_en,
    output logic       mclk_en,
    output logic       exec_en,
    output logic       sg_cycle,
    output logic       hlda
);
    cs_state_e st_q, st_d, ret_st;
    logic pend_q, pend_d, sg_q, sg_d, hlda_q, hlda_d;
    logic push, pop, restart_done;
    logic wake_irq, any_irq, stop_ok;

    assign wake_irq = irq_intr | irq_nmi | irq_smi | irq_reset | irq_init;
    assign any_irq  = wake_irq | irq_flush;
    assign stop_ok  = stop_req & ~any_irq;

    clkstop_retstack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_st(st_q), .top_st(ret_st)
    );

    clkstop_restart #(.CYCLES(RESTART_CYCLES)) u_restart (
        .clk(clk), .rst_n(rst_n), .run((st_q == CS_OFF) && ext_clk_ok),
        .done(restart_done)
    );

    clkstop_enables u_en (
        .st(st_q), .pll_en(pll_en), .mclk_en(mclk_en), .exec_en(exec_en)
    );

    // Next-state, stack control and stop-grant strobe selection.
    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        sg_d   = 1'b0;
        push   = 1'b0;
        pop    = 1'b0;
        unique case (st_q)
            CS_RUN: begin
                if (pend_q) begin
                    st_d = CS_GRANT; push = 1'b1; pend_d = 1'b0;
                end else if (halt_stb) begin
                    st_d = CS_HALT;
                end else if (stop_ok && insn_done) begin
                    pend_d = 1'b1; sg_d = 1'b1;
                end
            end
            CS_HALT: begin
                if (pend_q) begin
                    st_d = CS_GRANT; push = 1'b1; pend_d = 1'b0;
                end else if (wake_irq) begin
                    st_d = CS_RUN;
                end else if (inq_stb) begin
                    st_d = CS_SNOOP; push = 1'b1;
                end else if (stop_ok) begin
                    pend_d = 1'b1; sg_d = 1'b1;
                end
            end
            CS_GRANT: begin
                if (inq_stb) begin
                    st_d = CS_SNOOP; push = 1'b1;
                end else if (!ext_clk_ok) begin
                    st_d = CS_OFF; push = 1'b1;
                end else if (!stop_req) begin
                    st_d = ret_st; pop = 1'b1;
                end
            end
            CS_SNOOP: begin
                if (coh_done) begin
                    st_d = ret_st; pop = 1'b1;
                end
            end
            CS_OFF: begin
                if (restart_done) begin
                    st_d = ret_st; pop = 1'b1;
                end
            end
            default: st_d = CS_RUN;
        endcase
    end

    // Hold acknowledge: needs a running clock to be granted in clock off, but drops without one.
    assign hlda_d = hold_req && (hlda_q || (st_q != CS_OFF) || ext_clk_ok);

    // State, pending flag, strobe and acknowledge registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CS_RUN;
            pend_q <= 1'b0;
            sg_q   <= 1'b0;
            hlda_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
            sg_q   <= sg_d;
            hlda_q <= hlda_d;
        end
    end

    assign cur_state = st_q;
    assign sg_cycle  = sg_q;
    assign hlda      = hlda_q;
endmodule

// File: rtl/clkstop_ctrl_chk.sv
// Protocol checker for clkstop_ctrl, attached by bind.
// Assumes: the state codes match the package encoding.
module clkstop_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_req,
    input logic       inq_stb,
    input logic       coh_done,
    input logic       ext_clk_ok,
    input logic       hold_req,
    input logic       wake,
    input logic [2:0] state,
    input logic       sg_cycle,
    input logic       hlda,
    input logic       pll_en,
    input logic       mclk_en,
    input logic       exec_en
);
    // R4
    sg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sg_cycle |=> (!sg_cycle && state == 3'd2));
    // R4
    grant_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd2 && $past(state) != 3'd2 && $past(state) != 3'd3 && $past(state) != 3'd4)
        |-> $past(sg_cycle));
    // R3
    halt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd0 && $past(state) == 3'd1) |-> $past(wake));
    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd2 && stop_req && !inq_stb && ext_clk_ok) |=> state == 3'd2);
    // R8
    snoop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd3 && !coh_done) |=> state == 3'd3);
    // R9
    off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == 3'd4 |=> (state == 3'd4 || state == 3'd2));
    // R11
    hlda_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd4 && !hold_req) |=> !hlda);
    // R10
    exec_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |-> (mclk_en && pll_en));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .inq_stb(inq_stb),
    .coh_done(coh_done), .ext_clk_ok(ext_clk_ok), .hold_req(hold_req),
    .wake(irq_intr | irq_nmi | irq_smi | irq_reset | irq_init),
    .state(cur_state), .sg_cycle(sg_cycle), .hlda(hlda),
    .pll_en(pll_en), .mclk_en(mclk_en), .exec_en(exec_en)
);

// File: tb/clkstop_ctrl_bench.sv
// Directed bench for clkstop_ctrl: one task per scenario, each checking its own results.
module clkstop_ctrl_bench;
    localparam int NCYC = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, insn_done = 0, halt_stb = 0;
    logic irq_intr = 0, irq_nmi = 0, irq_smi = 0, irq_reset = 0, irq_init = 0, irq_flush = 0;
    logic inq_stb = 0, coh_done = 0, ext_clk_ok = 1, hold_req = 0;
    logic [2:0] cur_state;
    logic pll_en, mclk_en, exec_en, sg_cycle, hlda;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    clkstop_ctrl #(.RESTART_CYCLES(NCYC)) u_clkstop_ctrl (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .insn_done(insn_done),
        .halt_stb(halt_stb), .irq_intr(irq_intr), .irq_nmi(irq_nmi), .irq_smi(irq_smi),
        .irq_reset(irq_reset), .irq_init(irq_init), .irq_flush(irq_flush),
        .inq_stb(inq_stb), .coh_done(coh_done), .ext_clk_ok(ext_clk_ok),
        .hold_req(hold_req), .cur_state(cur_state), .pll_en(pll_en),
        .mclk_en(mclk_en), .exec_en(exec_en), .sg_cycle(sg_cycle), .hlda(hlda)
    );

    // Advance one clock and sample 1 ns after the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected enables per state code (R10).
    task automatic chk_en(input int st);
        chk("R10", "pll_en", int'(pll_en), (st != 4) ? 1 : 0);
        chk("R10", "mclk_en", int'(mclk_en), (st == 0 || st == 1 || st == 3) ? 1 : 0);
        chk("R10", "exec_en", int'(exec_en), (st == 0) ? 1 : 0);
    endtask

    task automatic t_reset();
        rst_n = 0;
        step();
        step();
        rst_n = 1;
        chk("R1", "state", int'(cur_state), 0);
        chk("R1", "sg_cycle", int'(sg_cycle), 0);
        chk("R1", "hlda", int'(hlda), 0);
        chk_en(0);
    endtask

    task automatic t_halt();
        halt_stb = 1; step(); halt_stb = 0;
        chk("R2", "state after halt", int'(cur_state), 1);
        chk_en(1);
        irq_flush = 1; step(); irq_flush = 0;
        chk("R3", "flush leaves halted", int'(cur_state), 1);
        irq_intr = 1; step(); irq_intr = 0;
        chk("R3", "intr wakes", int'(cur_state), 0);
    endtask

    task automatic t_inq_run();
        inq_stb = 1; step(); inq_stb = 0;
        chk("R12", "inquire in run", int'(cur_state), 0);
    endtask

    task automatic t_stop_run();
        stop_req = 1; insn_done = 0; step();
        chk("R4", "wait for insn", int'(sg_cycle), 0);
        insn_done = 1; step(); insn_done = 0;
        chk("R4", "strobe", int'(sg_cycle), 1);
        chk("R4", "still run", int'(cur_state), 0);
        stop_req = 0; step();
        chk("R6", "grant despite negation", int'(cur_state), 2);
        chk("R4", "strobe one cycle", int'(sg_cycle), 0);
        chk_en(2);
        step();
        chk("R7", "return to run", int'(cur_state), 0);
    endtask

    task automatic t_priority();
        insn_done = 1; irq_nmi = 1; stop_req = 1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R5", "held off strobe", int'(sg_cycle), 0);
            chk("R5", "held off state", int'(cur_state), 0);
        end
        irq_nmi = 0; step(); insn_done = 0;
        chk("R4", "strobe after irq", int'(sg_cycle), 1);
        step();
        chk("R4", "grant", int'(cur_state), 2);
        irq_nmi = 1; irq_smi = 1; step(); step();
        chk("R7", "irq no exit", int'(cur_state), 2);
        irq_nmi = 0; irq_smi = 0; stop_req = 0; step();
        chk("R7", "back to run", int'(cur_state), 0);
    endtask

    task automatic t_nested();
        halt_stb = 1; step(); halt_stb = 0;
        stop_req = 1; step();
        chk("R4", "strobe from halt", int'(sg_cycle), 1);
        step();
        chk("R4", "grant from halt", int'(cur_state), 2);
        inq_stb = 1; step(); inq_stb = 0;
        chk("R8", "snoop", int'(cur_state), 3);
        chk_en(3);
        step();
        chk("R8", "snoop holds", int'(cur_state), 3);
        coh_done = 1; step(); coh_done = 0;
        chk("R8", "back to grant", int'(cur_state), 2);
        stop_req = 0; step();
        chk("R8", "unwind to halted", int'(cur_state), 1);
        inq_stb = 1; step(); inq_stb = 0;
        chk("R8", "snoop from halted", int'(cur_state), 3);
        coh_done = 1; step(); coh_done = 0;
        chk("R8", "back to halted", int'(cur_state), 1);
        irq_init = 1; step(); irq_init = 0;
        chk("R3", "init wakes", int'(cur_state), 0);
    endtask

    task automatic t_off();
        stop_req = 1; insn_done = 1; step(); insn_done = 0; step();
        chk("R9", "grant before off", int'(cur_state), 2);
        ext_clk_ok = 0; step();
        chk("R9", "clock off", int'(cur_state), 4);
        chk_en(4);
        hold_req = 1; step(); step();
        chk("R11", "no hlda without clock", int'(hlda), 0);
        ext_clk_ok = 1; step();
        chk("R11", "hlda with clock", int'(hlda), 1);
        ext_clk_ok = 0; hold_req = 0; step();
        chk("R11", "hlda released clockless", int'(hlda), 0);
        chk("R9", "still off", int'(cur_state), 4);
        ext_clk_ok = 1;
        for (int i = 0; i < NCYC - 1; i++) step();
        chk("R9", "window not over", int'(cur_state), 4);
        step();
        chk("R9", "restart to grant", int'(cur_state), 2);
        stop_req = 0; step();
        chk("R7", "unwind to run", int'(cur_state), 0);
    endtask

    task automatic t_hlda_run();
        hold_req = 1; step();
        chk("R11", "hlda in run", int'(hlda), 1);
        hold_req = 0; step();
        chk("R11", "hlda drops", int'(hlda), 0);
    endtask

    initial begin
        #2;
        t_reset();
        t_halt();
        t_inq_run();
        t_stop_run();
        t_priority();
        t_nested();
        t_off();
        t_hlda_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule